// File: doc/BRIEF.md
# Display Controller Serial Command Receiver

This block is the two-wire serial slave front end of a small display controller. It synchronises the clock and data lines into the system clock domain and recognises start and stop conditions. It accepts an addressed transaction when the seven-bit address matches its own. The upper five bits of that address are fixed at 01111, and the lowest two bits come from strap pins.

In a write, the block alternates between control bytes and data bytes. A control byte carries two flags. The destination flag sends the following data either to a command strobe or to a display RAM write port. The continuation flag says whether one data byte follows and then a new control byte, or whether every byte up to the stop condition is stream data. RAM writes go to a data pointer that steps forward after each write and wraps at the end of the 918-byte display memory, which holds 102 columns by 65 rows at one bit per pixel. In a read, the block returns a status byte taken from an input port. Each byte the block accepts is acknowledged by pulling the data line low on the ninth clock pulse.

Top module: `disp_i2c_rx`

## Requirements
- R1: The device address is the 7-bit value {01111, addrStrap[1], addrStrap[0]}, sent most significant bit first and followed by a read/write bit (0 = write, 1 = read). A matching address byte is acknowledged, and sdaPullLow is high during the ninth SCL pulse.
- R2: If the address does not match, the block leaves the line released for the rest of the transfer and raises no strobe until the next START.
- R3: In a write, every control byte and every data byte after a matching address is acknowledged on its ninth SCL pulse.
- R4: Only bit 7 (continuation) and bit 6 (destination) of a control byte have any effect. Bits 5 to 0 are ignored.
- R5: A data byte with destination 0 produces a one-cycle cmdValid pulse with cmdByte equal to the byte. A data byte with destination 1 produces a one-cycle ramWrEn pulse with ramData equal to the byte. The two pulses never occur in the same cycle.
- R6: With continuation 1, exactly one data byte follows and the next byte is a control byte. With continuation 0, every byte up to STOP is a data byte for the same destination.
- R7: Each RAM write goes to the address shown on ramAddr. The pointer then advances by one and wraps from 917 to 0. It changes at no other time, and it keeps its value across transactions.
- R8: After a matching address with the read bit set, the block sends the statusIn byte most significant bit first. statusIn is sampled again at each master acknowledge. After a master not-acknowledge, the block releases the line until the next START.
- R9: sdaPullLow changes only while SCL is low.
- R10: A STOP, or a repeated START at any point, ends the current parse. Any partly received byte is discarded and produces no strobe. After a repeated START the next byte is read as an address byte.
- R11: After reset, sdaPullLow, cmdValid and ramWrEn are low and ramAddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| addrStrap | input | 2 | Strap levels giving the two low address bits |
| statusIn | input | 8 | Status byte returned in reads |
| cmdValid | output | 1 | One-cycle strobe for a command byte |
| cmdByte | output | 8 | Command byte, valid with cmdValid |
| ramWrEn | output | 1 | One-cycle display RAM write request |
| ramAddr | output | ADDR_W | Data pointer, the write address while ramWrEn is high |
| ramData | output | 8 | RAM data byte, valid with ramWrEn |

## Verification
A bus level seen on the pins reaches the parser after two synchroniser stages and one edge-compare stage. A command or RAM strobe therefore rises on the third clock edge after the eighth SCL rise of its byte, and the acknowledge pull changes on the third edge after the SCL fall that starts its slot. The bench holds each SCL half period for four clocks, so it samples the acknowledge and the read bits two clocks into the SCL high phase, when they have settled and are not yet allowed to change. The strobes are not expected at a fixed cycle. The monitor compares every strobe, at the falling clock edge, against the next item that the bus driver queued for that byte, so a strobe that is missing, extra, misrouted or at a wrong address is reported.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;
  // bus events seen in the system clock domain
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } busEvt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic cmdStb;
    logic ramStb;
  } dpStb_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CTRL, ST_DATA, ST_READ, ST_SKIP
  } rxState_t;
endpackage

// File: rtl/disp_i2c_dp.sv
module disp_i2c_dp
  import disp_i2c_pkg::*;
#(
  parameter int RAM_DEPTH   = 918,
  parameter int ADDR_W      = $clog2(RAM_DEPTH),
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [7:0]        statusIn,
  input  dpStb_t            stb,
  output busEvt_t           evt,
  output logic              sdaNow,
  output logic [7:0]        rxByte,
  output logic [7:0]        txByte,
  output logic              cmdValid,
  output logic [7:0]        cmdByte,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData
);
  localparam logic [ADDR_W-1:0] LastAddr = ADDR_W'(RAM_DEPTH - 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclNow, sclPrev, sdaPrev;
  logic [6:0] shiftReg;

  // two-flop synchronisers, idle bus is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    evt.sclRise   = sclNow & ~sclPrev;
    evt.sclFall   = ~sclNow & sclPrev;
    evt.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  end

  assign rxByte = {shiftReg, sdaNow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txByte   <= '0;
      cmdValid <= 1'b0;
      cmdByte  <= '0;
      ramWrEn  <= 1'b0;
      ramData  <= '0;
      ramAddr  <= '0;
    end else begin
      if (stb.shiftIn) shiftReg <= rxByte[6:0];
      if (stb.loadTx)  txByte   <= statusIn;
      cmdValid <= stb.cmdStb;
      ramWrEn  <= stb.ramStb;
      if (stb.cmdStb) cmdByte <= rxByte;
      if (stb.ramStb) ramData <= rxByte;
      // pointer steps once the write cycle has been presented
      if (ramWrEn) ramAddr <= (ramAddr == LastAddr) ? '0 : ramAddr + 1'b1;
    end
  end
endmodule

// File: rtl/disp_i2c_ctrl.sv
module disp_i2c_ctrl
  import disp_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b01111
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic       sdaNow,
  input  logic [7:0] rxByte,
  input  logic [7:0] txByte,
  input  logic [1:0] addrStrap,
  output dpStb_t     stb,
  output logic       sdaPullLow
);
  rxState_t   state;
  logic [3:0] bitCnt;
  logic       coBit, dcBit, ackThis;
  logic       busy, addrHit, lastBit, ackSlot;

  assign busy    = state inside {ST_ADDR, ST_CTRL, ST_DATA, ST_READ};
  assign addrHit = rxByte[7:1] == {ADDR_HI, addrStrap};
  assign lastBit = evt.sclRise && busy && bitCnt == 4'd7;
  assign ackSlot = evt.sclRise && busy && bitCnt == 4'd8;

  always_comb begin
    stb = '0;
    stb.shiftIn = evt.sclRise && busy;
    if (lastBit && state == ST_DATA) begin
      stb.cmdStb = ~dcBit;
      stb.ramStb = dcBit;
    end
    if (lastBit && state == ST_ADDR && addrHit && rxByte[0]) stb.loadTx = 1'b1;
    if (ackSlot && state == ST_READ && !sdaNow) stb.loadTx = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      coBit      <= 1'b0;
      dcBit      <= 1'b0;
      ackThis    <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (evt.stopSeen || evt.startSeen) begin
      state      <= evt.startSeen ? ST_ADDR : ST_IDLE;
      bitCnt     <= '0;
      ackThis    <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      if (ackSlot) begin
        bitCnt <= '0;
        if (state == ST_READ && sdaNow) state <= ST_SKIP;
      end else if (evt.sclRise && busy) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == 4'd7) begin
          unique case (state)
            ST_ADDR: begin
              ackThis <= addrHit;
              if (!addrHit)       state <= ST_SKIP;
              else if (rxByte[0]) state <= ST_READ;
              else                state <= ST_CTRL;
            end
            ST_CTRL: begin
              ackThis <= 1'b1;
              coBit   <= rxByte[7];
              dcBit   <= rxByte[6];
              state   <= ST_DATA;
            end
            ST_DATA: begin
              ackThis <= 1'b1;
              if (coBit) state <= ST_CTRL;
            end
            default: ackThis <= 1'b0;
          endcase
        end
      end
      if (evt.sclFall) begin
        if (bitCnt == 4'd8)        sdaPullLow <= ackThis;
        else if (state == ST_READ) sdaPullLow <= ~txByte[~bitCnt[2:0]];
        else                       sdaPullLow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/disp_i2c_rx.sv
module disp_i2c_rx
  import disp_i2c_pkg::*;
#(
  parameter int RAM_DEPTH = 918,
  parameter int ADDR_W    = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic [1:0]        addrStrap,
  input  logic [7:0]        statusIn,
  output logic              cmdValid,
  output logic [7:0]        cmdByte,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData
);
  busEvt_t    evt;
  dpStb_t     stb;
  logic       sdaNow;
  logic [7:0] rxByte, txByte;

  disp_i2c_dp #(.RAM_DEPTH(RAM_DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .statusIn(statusIn),
    .stb(stb), .evt(evt), .sdaNow(sdaNow), .rxByte(rxByte), .txByte(txByte),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .ramWrEn(ramWrEn),
    .ramAddr(ramAddr), .ramData(ramData)
  );

  disp_i2c_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .sdaNow(sdaNow), .rxByte(rxByte),
    .txByte(txByte), .addrStrap(addrStrap), .stb(stb), .sdaPullLow(sdaPullLow)
  );
endmodule

// File: rtl/disp_i2c_rx_chk.sv
module disp_i2c_rx_chk #(
  parameter int RAM_DEPTH = 918,
  parameter int ADDR_W    = $clog2(RAM_DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullLow,
  input logic              cmdValid,
  input logic              ramWrEn,
  input logic [ADDR_W-1:0] ramAddr
);
  localparam logic [ADDR_W-1:0] LastAddr = ADDR_W'(RAM_DEPTH - 1);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && ramWrEn)); // R5
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R5
  AST_RAM_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |=> !ramWrEn); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |=> ramAddr == (($past(ramAddr) == LastAddr) ? '0 : $past(ramAddr) + 1'b1)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ramWrEn |=> $stable(ramAddr)); // R7
  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn); // R9
  AST_RELEASE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclIn); // R9
endmodule

bind disp_i2c_rx disp_i2c_rx_chk #(.RAM_DEPTH(RAM_DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .cmdValid(cmdValid), .ramWrEn(ramWrEn), .ramAddr(ramAddr)
);

// File: tb/test_disp_i2c_rx.sv
module test_disp_i2c_rx;
  localparam int RAM_DEPTH = 918;
  localparam int ADDR_W    = $clog2(RAM_DEPTH);
  localparam int HALF      = 4;

  typedef struct packed {
    logic              isRam;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaDrv = 1'b1;
  logic [1:0] addrStrap = 2'b10;
  logic [7:0] statusIn = 8'h00;
  logic sdaPullLow, cmdValid, ramWrEn;
  logic [7:0] cmdByte, ramData;
  logic [ADDR_W-1:0] ramAddr;
  logic sdaBus;

  int checks = 0;
  int errors = 0;
  int expPtr = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  assign sdaBus = sdaDrv & ~sdaPullLow;

  always #10 clk = ~clk;

  disp_i2c_rx i_disp_i2c_rx (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaBus), .sdaPullLow(sdaPullLow),
    .addrStrap(addrStrap), .statusIn(statusIn), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .ramWrEn(ramWrEn), .ramAddr(ramAddr), .ramData(ramData)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expCmd(input logic [7:0] b);
    expQ.push_back('{isRam: 1'b0, addr: '0, data: b});
  endtask

  task automatic expRam(input logic [7:0] b);
    expQ.push_back('{isRam: 1'b1, addr: ADDR_W'(expPtr), data: b});
    expPtr = (expPtr == RAM_DEPTH - 1) ? 0 : expPtr + 1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && (cmdValid || ramWrEn)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 R10 unexpected strobe", {ramWrEn, ramAddr, ramWrEn ? ramData : cmdByte}, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.isRam)
          check(ramWrEn && ramAddr == e.addr && ramData == e.data, "R5 R7 ram write",
                {ramWrEn, ramAddr, ramData}, {1'b1, e.addr, e.data});
        else
          check(cmdValid && cmdByte == e.data, "R5 command", {cmdValid, cmdByte}, {1'b1, e.data});
      end
    end
  end

  task automatic startCond();
    sdaDrv = 1'b1; waitClk(HALF);
    sclIn = 1'b1; waitClk(HALF);
    sdaDrv = 1'b0; waitClk(HALF);
    sclIn = 1'b0; waitClk(1);
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitClk(HALF);
    sclIn = 1'b1; waitClk(HALF);
    sdaDrv = 1'b1; waitClk(HALF);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; waitClk(HALF);
      sclIn = 1'b1; waitClk(HALF);
      sclIn = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    sendBits(b, 8);
    sdaDrv = 1'b1; waitClk(HALF);
    sclIn = 1'b1; waitClk(2);
    check((sdaBus == 1'b0) == expAck, tag, !sdaBus, expAck);
    waitClk(2);
    sclIn = 1'b0;
  endtask

  task automatic readByte(input logic [7:0] expB, input logic masterAck, input string tag);
    logic [7:0] got;
    int unstable;
    unstable = 0;
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic early;
      waitClk(HALF);
      sclIn = 1'b1; waitClk(1);
      early = sdaBus; waitClk(1);
      got[i] = sdaBus; waitClk(2);
      if (early != sdaBus) unstable++;
      sclIn = 1'b0;
    end
    check(got == expB, tag, got, expB);
    check(unstable == 0, "R9 data stable while SCL high", unstable, 0);
    sdaDrv = ~masterAck; waitClk(HALF);
    sclIn = 1'b1; waitClk(HALF);
    sclIn = 1'b0; waitClk(1);
    sdaDrv = 1'b1;
  endtask

  initial begin
    waitClk(5);
    check(!sdaPullLow && !cmdValid && !ramWrEn && ramAddr == 0, "R11 reset state",
          {sdaPullLow, cmdValid, ramWrEn, ramAddr}, 0);
    rstN = 1'b1;
    waitClk(4);

    // strap 10 -> address 0x3E, write byte 0x7C
    startCond();
    sendByte(8'h7C, 1'b1, "R1 address ack");
    sendByte(8'h80, 1'b1, "R3 control ack");
    expCmd(8'h21);
    sendByte(8'h21, 1'b1, "R3 data ack");
    sendByte(8'hC0, 1'b1, "R6 control after single byte");
    expRam(8'h55);
    sendByte(8'h55, 1'b1, "R3 ram data ack");
    sendByte(8'h3F, 1'b1, "R4 control with low bits set");
    expCmd(8'h11); sendByte(8'h11, 1'b1, "R6 command stream");
    expCmd(8'h12); sendByte(8'h12, 1'b1, "R6 command stream");
    expCmd(8'hC5); sendByte(8'hC5, 1'b1, "R6 stream byte resembling control");
    stopCond();

    // ram stream, junk low control bits
    startCond();
    sendByte(8'h7C, 1'b1, "R1 address ack");
    sendByte(8'h55, 1'b1, "R4 control 0x55 is ram stream");
    for (int i = 0; i < 3; i++) begin
      expRam(8'hA0 + 8'(i));
      sendByte(8'hA0 + 8'(i), 1'b1, "R6 ram stream ack");
    end
    stopCond();

    // wrong address ignored
    startCond();
    sendByte(8'h7E, 1'b0, "R2 mismatched address no ack");
    sendByte(8'h80, 1'b0, "R2 later byte no ack");
    sendByte(8'h33, 1'b0, "R2 later byte no ack");
    stopCond();

    // new strap value
    addrStrap = 2'b01;
    startCond();
    sendByte(8'h7C, 1'b0, "R1 old address rejected");
    stopCond();
    startCond();
    sendByte(8'h7A, 1'b1, "R1 strap 01 address ack");
    sendByte(8'h80, 1'b1, "R3 control ack");
    expCmd(8'h44); sendByte(8'h44, 1'b1, "R5 command byte");
    stopCond();

    // abort by stop, then by repeated start
    startCond();
    sendByte(8'h7A, 1'b1, "R1 address ack");
    sendByte(8'hC0, 1'b1, "R3 control ack");
    sendBits(8'hF0, 4);
    stopCond();
    startCond();
    sendByte(8'h7A, 1'b1, "R1 address ack");
    sendByte(8'h80, 1'b1, "R3 control ack");
    sendBits(8'hE0, 3);
    startCond();
    sendByte(8'h7A, 1'b1, "R10 address after repeated start");
    sendByte(8'h80, 1'b1, "R10 control after repeated start");
    expCmd(8'h66); sendByte(8'h66, 1'b1, "R10 command after abort");
    stopCond();

    // read mode
    statusIn = 8'hA5;
    startCond();
    sendByte(8'h7B, 1'b1, "R8 read address ack");
    statusIn = 8'h3C;
    readByte(8'hA5, 1'b1, "R8 first status byte");
    readByte(8'h3C, 1'b0, "R8 status resampled at ack");
    readByte(8'hFF, 1'b1, "R8 released after nack");
    stopCond();

    // pointer wrap across a long stream
    startCond();
    sendByte(8'h7A, 1'b1, "R1 address ack");
    sendByte(8'h40, 1'b1, "R3 control ack");
    for (int i = 0; i < RAM_DEPTH; i++) begin
      expRam(8'(i));
      sendByte(8'(i), 1'b1, "R7 wrap stream ack");
    end
    stopCond();
    startCond();
    sendByte(8'h7A, 1'b1, "R1 address ack");
    sendByte(8'hC0, 1'b1, "R3 control ack");
    expRam(8'h9D); sendByte(8'h9D, 1'b1, "R7 pointer kept across transfers");
    stopCond();

    waitClk(10);
    check(expQ.size() == 0, "R5 R7 all expected strobes seen", expQ.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule